// File: doc/BRIEF.md
# Hybrid Static-Dynamic Branch Direction Predictor

This block predicts whether a conditional branch will be taken. It uses two mechanisms. The first is a fixed direction rule that needs no stored state: a branch that jumps to a lower address is predicted taken, and a branch that jumps to the same or a higher address is predicted not-taken. The second is a direct-mapped, tagged table. Each entry holds a short shift register of the recent outcomes of one branch. That outcome pattern selects one of a set of shared two-bit saturating counters, and the chosen counter gives the learned direction.

A lookup is combinational. The front end presents a branch address and its target address in the same cycle and gets back a direction and a hit flag. When the branch is found in the table, the learned direction is returned. When it is not found, the fixed rule decides.

When the branch resolves, the back end presents the branch address and the actual outcome on the update port. If the branch is already tracked, its counter moves one step toward the outcome and its outcome pattern shifts. If it is not tracked, the slot at its index is claimed for it.

Top module: `hybrid_branch_predictor`

## Requirements
- R1: On a miss, `lk_taken_o` is 1 when `lk_tgt_i` is strictly below `lk_pc_i`. When the two are equal or the target is above, it is 0.
- R2: `lk_hit_o` is 1 exactly when the entry at index `lk_pc_i[IDX_W-1:0]` is valid and its stored tag equals `lk_pc_i[ADDR_W-1:IDX_W]`.
- R3: On a hit, `lk_taken_o` equals bit 1 of the counter selected by that entry's 4-bit history. This means taken when the counter value is 2 or 3. The fixed rule has no influence on a hit.
- R4: An update that misses writes the entry at its index. The entry becomes valid, takes the update's tag, and gets a history in which all four bits equal the actual outcome. No counter changes on a miss.
- R5: An update that hits steps the counter selected by the entry's old history: up by one if taken, down by one if not taken. In the same cycle the history shifts left and the outcome enters at bit 0.
- R6: Counters saturate. A taken update leaves a counter at 3, and a not-taken update leaves a counter at 0.
- R7: A lookup in the same cycle as an update sees the state from before that update. The new state is visible from the next cycle on.
- R8: After reset, every entry is invalid and every counter holds 1 (weakly not-taken).
- R9: An update that misses on a valid entry with a different tag at the same index replaces that entry. A later lookup of the old branch misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| lk_pc_i | input | ADDR_W | Lookup branch address |
| lk_tgt_i | input | ADDR_W | Lookup branch target address |
| lk_taken_o | output | 1 | Predicted direction (1 = taken) |
| lk_hit_o | output | 1 | Lookup branch is tracked in the table |
| up_valid_i | input | 1 | Resolved branch update strobe |
| up_pc_i | input | ADDR_W | Resolved branch address |
| up_taken_i | input | 1 | Actual outcome of the resolved branch |

## Verification
The bench checks targets that sit exactly at the branch address. A design that used a less-or-equal compare would wrongly predict taken for these.

It trains the same branch with a backward target and checks that the table overrides the rule once the branch is tracked. A design that did not let the table take over would keep returning the static answer.

It aims two branches with different tags at one index. A design that ignored the tag would report a false hit. A design that refused to replace a valid entry would keep predicting from the old branch.

Long runs of one outcome drive the counters to both ends of their range. A design without saturation would wrap from 3 to 0 and flip its prediction.

Every update is paired with a lookup in the same cycle. A design that forwarded the new state into that lookup would answer one update too early.

// File: rtl/bp_pkg.sv
package bp_pkg;
  localparam int CTR_W = 2;
  typedef logic [CTR_W-1:0] ctr_t;

  localparam ctr_t CTR_MAX   = '1;
  localparam ctr_t CTR_RESET = ctr_t'(1);

  function automatic ctr_t ctr_step(input ctr_t c, input logic up);
    ctr_t n;
    n = c;
    if (up && c != CTR_MAX)       n = c + ctr_t'(1);
    else if (!up && c != '0)      n = c - ctr_t'(1);
    return n;
  endfunction
endpackage

// File: rtl/bp_static_rule.sv
module bp_static_rule #(
  parameter int ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [ADDR_W-1:0] tgt_i,
  output logic              taken_o
);
  // backward jump -> taken, forward or self -> not taken
  assign taken_o = (tgt_i < pc_i);
endmodule

// File: rtl/bp_counter_table.sv
module bp_counter_table
  import bp_pkg::*;
#(
  parameter int HIST_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [HIST_W-1:0] rd_idx_i,
  output logic              rd_taken_o,
  input  logic              upd_en_i,
  input  logic [HIST_W-1:0] upd_idx_i,
  input  logic              upd_taken_i
);
  localparam int CTRS = 1 << HIST_W;

  ctr_t ctr_q [CTRS];

  for (genvar g = 0; g < CTRS; g++) begin : g_ctr
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        ctr_q[g] <= CTR_RESET;
      else if (upd_en_i && upd_idx_i == HIST_W'(g))
        ctr_q[g] <= ctr_step(ctr_q[g], upd_taken_i);
    end
  end

  assign rd_taken_o = ctr_q[rd_idx_i][CTR_W-1];

  assert_sat_hi_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_en_i && upd_taken_i && ctr_q[upd_idx_i] == CTR_MAX)
      |=> ctr_q[$past(upd_idx_i)] == CTR_MAX);

  assert_sat_lo_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_en_i && !upd_taken_i && ctr_q[upd_idx_i] == '0)
      |=> ctr_q[$past(upd_idx_i)] == '0);

  assert_step_up_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_en_i && upd_taken_i && ctr_q[upd_idx_i] != CTR_MAX)
      |=> ctr_q[$past(upd_idx_i)] == $past(ctr_q[upd_idx_i]) + ctr_t'(1));
endmodule

// File: rtl/bp_history_table.sv
module bp_history_table #(
  parameter int ADDR_W = 16,
  parameter int IDX_W  = 6,
  parameter int HIST_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] rd_pc_i,
  output logic              rd_hit_o,
  output logic [HIST_W-1:0] rd_hist_o,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_pc_i,
  input  logic              wr_taken_i,
  output logic              wr_hit_o,
  output logic [HIST_W-1:0] wr_hist_o
);
  localparam int ENTRIES = 1 << IDX_W;
  localparam int TAG_W   = ADDR_W - IDX_W;

  logic              vld_q  [ENTRIES];
  logic [TAG_W-1:0]  tag_q  [ENTRIES];
  logic [HIST_W-1:0] hist_q [ENTRIES];

  logic [IDX_W-1:0] rd_idx, wr_idx;
  logic [TAG_W-1:0] rd_tag, wr_tag;

  assign rd_idx = rd_pc_i[IDX_W-1:0];
  assign rd_tag = rd_pc_i[ADDR_W-1:IDX_W];
  assign wr_idx = wr_pc_i[IDX_W-1:0];
  assign wr_tag = wr_pc_i[ADDR_W-1:IDX_W];

  assign rd_hit_o  = vld_q[rd_idx] && (tag_q[rd_idx] == rd_tag);
  assign rd_hist_o = hist_q[rd_idx];
  assign wr_hit_o  = vld_q[wr_idx] && (tag_q[wr_idx] == wr_tag);
  assign wr_hist_o = hist_q[wr_idx];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q[g]  <= 1'b0;
        tag_q[g]  <= '0;
        hist_q[g] <= '0;
      end else if (wr_en_i && wr_idx == IDX_W'(g)) begin
        vld_q[g] <= 1'b1;
        tag_q[g] <= wr_tag;
        if (wr_hit_o) hist_q[g] <= {hist_q[g][HIST_W-2:0], wr_taken_i};
        else          hist_q[g] <= {HIST_W{wr_taken_i}};
      end
    end
  end

  assert_alloc_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !wr_hit_o)
      |=> (vld_q[$past(wr_idx)] && tag_q[$past(wr_idx)] == $past(wr_tag)
           && hist_q[$past(wr_idx)] == {HIST_W{$past(wr_taken_i)}}));

  assert_shift_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_hit_o)
      |=> hist_q[$past(wr_idx)] == {$past(wr_hist_o[HIST_W-2:0]), $past(wr_taken_i)});
endmodule

// File: rtl/hybrid_branch_predictor.sv
module hybrid_branch_predictor #(
  parameter int ADDR_W = 16,
  parameter int IDX_W  = 6,
  parameter int HIST_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] lk_pc_i,
  input  logic [ADDR_W-1:0] lk_tgt_i,
  output logic              lk_taken_o,
  output logic              lk_hit_o,
  input  logic              up_valid_i,
  input  logic [ADDR_W-1:0] up_pc_i,
  input  logic              up_taken_i
);
  logic              static_taken;
  logic              dyn_taken;
  logic [HIST_W-1:0] lk_hist;
  logic              up_hit;
  logic [HIST_W-1:0] up_hist;

  bp_static_rule #(.ADDR_W(ADDR_W)) u_static (
    .pc_i    (lk_pc_i),
    .tgt_i   (lk_tgt_i),
    .taken_o (static_taken)
  );

  bp_history_table #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .HIST_W(HIST_W)) u_hist (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_pc_i    (lk_pc_i),
    .rd_hit_o   (lk_hit_o),
    .rd_hist_o  (lk_hist),
    .wr_en_i    (up_valid_i),
    .wr_pc_i    (up_pc_i),
    .wr_taken_i (up_taken_i),
    .wr_hit_o   (up_hit),
    .wr_hist_o  (up_hist)
  );

  // counters only learn from tracked branches
  bp_counter_table #(.HIST_W(HIST_W)) u_ctr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rd_idx_i    (lk_hist),
    .rd_taken_o  (dyn_taken),
    .upd_en_i    (up_valid_i && up_hit),
    .upd_idx_i   (up_hist),
    .upd_taken_i (up_taken_i)
  );

  assign lk_taken_o = lk_hit_o ? dyn_taken : static_taken;

  assert_static_on_miss_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lk_hit_o |-> lk_taken_o == (lk_tgt_i < lk_pc_i));

  assert_hit_stable_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!up_valid_i && lk_hit_o && lk_pc_i == $past(lk_pc_i) && !$past(up_valid_i))
      |-> $past(lk_hit_o));
endmodule

// File: tb/tb_hybrid_branch_predictor.sv
`timescale 1ns/1ps
module tb_hybrid_branch_predictor;
  localparam int ADDR_W = 16;
  localparam int IDX_W  = 6;
  localparam int HIST_W = 4;
  localparam int ENT    = 1 << IDX_W;
  localparam int CTRS   = 1 << HIST_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [ADDR_W-1:0] lk_pc = '0, lk_tgt = '0, up_pc = '0;
  logic up_valid = 1'b0, up_taken = 1'b0;
  logic lk_taken, lk_hit;

  int checks = 0;
  int errors = 0;

  // bench model
  bit                m_vld  [ENT];
  bit [ADDR_W-IDX_W-1:0] m_tag [ENT];
  bit [HIST_W-1:0]   m_hist [ENT];
  int                m_ctr  [CTRS];

  always #2.5 clk = ~clk;

  hybrid_branch_predictor #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .HIST_W(HIST_W)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .lk_pc_i(lk_pc), .lk_tgt_i(lk_tgt), .lk_taken_o(lk_taken), .lk_hit_o(lk_hit),
    .up_valid_i(up_valid), .up_pc_i(up_pc), .up_taken_i(up_taken)
  );

  function automatic bit exp_hit(input logic [ADDR_W-1:0] pc);
    int i = int'(pc[IDX_W-1:0]);
    return m_vld[i] && m_tag[i] == pc[ADDR_W-1:IDX_W];
  endfunction

  function automatic bit exp_taken(input logic [ADDR_W-1:0] pc, input logic [ADDR_W-1:0] tgt);
    int i = int'(pc[IDX_W-1:0]);
    if (exp_hit(pc)) return m_ctr[m_hist[i]] >= 2;
    return tgt < pc;
  endfunction

  task automatic model_update(input logic [ADDR_W-1:0] pc, input bit t);
    int i = int'(pc[IDX_W-1:0]);
    if (exp_hit(pc)) begin
      int h = int'(m_hist[i]);
      if (t && m_ctr[h] < 3) m_ctr[h]++;
      if (!t && m_ctr[h] > 0) m_ctr[h]--;
      m_hist[i] = {m_hist[i][HIST_W-2:0], t};
    end else begin
      m_vld[i]  = 1'b1;
      m_tag[i]  = pc[ADDR_W-1:IDX_W];
      m_hist[i] = {HIST_W{t}};
    end
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  // one cycle: drive at negedge, check pre-edge outputs, then commit model
  task automatic step(input logic [ADDR_W-1:0] lpc, input logic [ADDR_W-1:0] ltgt,
                      input bit uv, input logic [ADDR_W-1:0] upc, input bit ut,
                      input string req);
    bit eh, et;
    @(negedge clk);
    lk_pc = lpc; lk_tgt = ltgt; up_valid = uv; up_pc = upc; up_taken = ut;
    #1;
    eh = exp_hit(lpc);
    et = exp_taken(lpc, ltgt);
    chk(lk_hit == eh,   {req, " hit"},   int'(lk_hit),   int'(eh));
    chk(lk_taken == et, {req, " taken"}, int'(lk_taken), int'(et));
    @(posedge clk);
    if (uv) model_update(upc, ut);
  endtask

  task automatic look(input logic [ADDR_W-1:0] lpc, input logic [ADDR_W-1:0] ltgt, input string req);
    step(lpc, ltgt, 1'b0, '0, 1'b0, req);
  endtask

  initial begin
    #(5.0 * 200000);
    errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    for (int i = 0; i < ENT; i++) begin m_vld[i] = 0; m_tag[i] = '0; m_hist[i] = '0; end
    for (int i = 0; i < CTRS; i++) m_ctr[i] = 1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R8 / R1: empty table, static rule over a sweep including equal addresses
    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 16; b++)
        look(ADDR_W'(a * 16'h0111 + 3), ADDR_W'(b * 16'h0111 + 3), "R8/R1 static sweep");

    // R4: allocate 0x1234 taken; backward target, counter[15]=1 -> dynamic not-taken
    step(16'h1234, 16'h1200, 1'b1, 16'h1234, 1'b1, "R7 same-cycle alloc");
    look(16'h1234, 16'h1200, "R4 alloc visible");
    look(16'h1234, 16'h1300, "R3 override forward");

    // R5/R6: repeated taken walks counter[15] to 3 and holds
    for (int k = 0; k < 6; k++)
      step(16'h1234, 16'h1200, 1'b1, 16'h1234, 1'b1, "R5/R6 saturate up");
    look(16'h1234, 16'h1300, "R6 high sat");
    for (int k = 0; k < 8; k++)
      step(16'h1234, 16'h1300, 1'b1, 16'h1234, 1'b0, "R5/R6 saturate down");
    look(16'h1234, 16'h1200, "R6 low sat");

    // R9: same index, other tag replaces the entry
    step(16'h5634, 16'h5600, 1'b1, 16'h5634, 1'b0, "R9 alias before");
    look(16'h1234, 16'h1200, "R9 old branch evicted");
    look(16'h5634, 16'h5600, "R9 new branch hit");

    // R2/R3/R5: pseudo-random mix on a small aliasing pool
    lfsr = 16'hACE1;
    for (int n = 0; n < 3000; n++) begin
      logic [ADDR_W-1:0] upc, lpc, tgt;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      upc = {7'(lfsr[3:1]), 3'b0, (lfsr[0] ? 6'd5 : 6'd9)};
      lpc = {7'(lfsr[7:5]), 3'b0, (lfsr[4] ? 6'd5 : 6'd9)};
      tgt = {lfsr[11:0], lfsr[15:12]};
      step(lpc, tgt, lfsr[8] | lfsr[9], upc, lfsr[10] ^ lfsr[14], "R2/R3/R5 mixed");
    end

    // R7: lookup of the updated branch in the update cycle and the next
    step(16'h0005, 16'h0001, 1'b1, 16'h0005, 1'b1, "R7 same-cycle hit");
    look(16'h0005, 16'h0001, "R7 next cycle");

    // R8: asynchronous reset clears everything
    @(negedge clk); rst_n = 1'b0; #1; rst_n = 1'b1;
    for (int i = 0; i < ENT; i++) m_vld[i] = 0;
    for (int i = 0; i < CTRS; i++) m_ctr[i] = 1;
    look(16'h0005, 16'h0001, "R8 after reset");
    look(16'h5634, 16'h5700, "R8 after reset fwd");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule